// File: doc/BRIEF.md
# Prefetch Request Queue With Outstanding Throttle

This block sits between a core's three hardware prefetch generators and the memory request path. The generators are the load-store stride detector, the instruction-fetch sequential fetcher and the page-table-walk descriptor fetcher. Each offers one cache-line address per cycle through a valid/ready handshake. A fixed priority accepts one of them per cycle into a shared in-order queue. A line already waiting in the queue or already in flight to memory is accepted at the handshake and then discarded, so memory never sees the same prefetch twice.

The head of the queue is offered to memory together with a slot tag. The number of issued but not yet completed prefetches is capped. At the cap, issue waits until memory returns a completion strobe carrying the tag of a busy slot. Every issued prefetch is marked so that its line is allocated into the L2 cache.

A demand read can look up its line address in the same cycle. If the line is in flight, the demand is told to take its data from the prefetch return and is given the slot tag. If the line is still waiting in the queue, the queued entry is withdrawn and the demand path takes over the request.

Top module: `pf_req_queue`

## Requirements
- R1: While reset is asserted and right after it, `issValid`, `issAlloc`, `dmdFwd` and `dmdTake` are low and all three `pushReady` bits are high.
- R2: Producer index 2 (table walk) has priority over index 1 (instruction fetch), which has priority over index 0 (load-store). A producer's `pushReady` is low whenever a higher-priority producer has `pushValid` high, and at most one line is accepted per cycle.
- R3: A line accepted while the same address is already queued or in flight is dropped: it is never issued and a demand for it finds nothing queued.
- R4: The queue holds DEPTH (16) lines. While it holds DEPTH lines, all `pushReady` bits are low and a push is refused. Removing one line raises them again in the next cycle.
- R5: Queued lines are issued oldest first, with `issAddr` the line and `issSrc` the producer code (0 load-store, 1 instruction fetch, 2 table walk). A line pushed with the queue empty appears on `issValid` in the next cycle.
- R6: With MAX_OUT (6) prefetches outstanding, `issValid` stays low. A completion of a busy slot lets issue resume in the following cycle.
- R7: `issTag` is the lowest-numbered free slot. `cmplValid` with `cmplTag` frees that slot. A completion naming a slot that is not busy has no effect.
- R8: In the cycle that `dmdValid` presents a line that is in flight, `dmdFwd` is high and `dmdFwdTag` gives the slot, and `dmdTake` is low.
- R9: In the cycle that `dmdValid` presents a line waiting in the queue, `dmdTake` is high. That line is removed and never issued, the lines behind it keep their order, and issue pauses for that cycle if the line was at the head.
- R10: `issAlloc` is high whenever `issValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 3 | Per-producer line offer (index 0 load-store, 1 instruction, 2 table walk) |
| pushAddr | input | 3 x LINE_W | Per-producer line address |
| pushReady | output | 3 | Per-producer acceptance |
| issValid | output | 1 | Prefetch request to memory |
| issReady | input | 1 | Memory accepts the request |
| issAddr | output | LINE_W | Line address being issued |
| issSrc | output | 2 | Producer code of the issued line |
| issTag | output | TAG_W | Slot tag given to the issued line |
| issAlloc | output | 1 | Allocate-into-L2 marking of the issued line |
| cmplValid | input | 1 | Memory completion strobe |
| cmplTag | input | TAG_W | Slot tag of the completion |
| dmdValid | input | 1 | Demand read lookup |
| dmdAddr | input | LINE_W | Demand line address |
| dmdFwd | output | 1 | Demand line is in flight; forward from its return |
| dmdFwdTag | output | TAG_W | Slot of the matching in-flight prefetch |
| dmdTake | output | 1 | Demand line was queued and has been withdrawn |

## Verification
The outstanding count and the slot busy bits describe the same state. If they disagree, the port shows it within a cycle or two of the next issue or completion. Issue would stop below the cap, a seventh request would appear, or a reused `issTag` would still be busy. A compaction fault in the queue shows as a wrong `issAddr` or `issSrc` on the next issue after a withdrawal. A broken duplicate filter shows as a second issue of a line whose first copy was still in flight. The bench drives each of these paths and reads the result at the ports in the exact cycle that the requirements give.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  localparam int NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_LS = 2'd0,
    SRC_IF = 2'd1,
    SRC_TW = 2'd2
  } srcE;

  // strobes from control to datapath, one cycle's worth of decisions
  typedef struct packed {
    logic push;
    srcE  pushSrc;
    logic pop;
    logic take;
    logic free;
  } ctrlS;

endpackage

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int MAX_OUT = 6,
  localparam int QCNT_W = $clog2(DEPTH + 1),
  localparam int OCNT_W = $clog2(MAX_OUT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pushValid,
  input  logic [NUM_SRC-1:0] dupVec,
  input  logic [QCNT_W-1:0]  qCount,
  input  logic               dmdValid,
  input  logic               dmdQHit,
  input  logic               dmdHeadHit,
  input  logic               dmdFHit,
  input  logic               issReady,
  input  logic               cmplValid,
  input  logic               cmplSlotBusy,
  output logic [NUM_SRC-1:0] pushReady,
  output logic               issValid,
  output logic               dmdFwd,
  output logic               dmdTake,
  output logic [OCNT_W-1:0]  outCnt,
  output ctrlS               ctrl
);

  logic       qFull;
  logic       anyWin;
  logic [1:0] winSel;
  logic       higher;

  // fixed priority: highest index wins, lower ones see ready drop
  always_comb begin
    qFull  = (qCount == QCNT_W'(DEPTH));
    higher = 1'b0;
    anyWin = 1'b0;
    winSel = 2'd0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      pushReady[s] = !qFull && !higher;
      if (pushValid[s] && !higher) begin
        anyWin = 1'b1;
        winSel = 2'(s);
      end
      higher = higher | pushValid[s];
    end
  end

  always_comb begin
    dmdFwd  = dmdValid && dmdFHit;
    dmdTake = dmdValid && dmdQHit && !dmdFHit;

    issValid = (qCount != '0) && (outCnt < OCNT_W'(MAX_OUT)) &&
               !(dmdTake && dmdHeadHit);

    ctrl.push    = anyWin && !qFull && !dupVec[winSel];
    ctrl.pushSrc = srcE'(winSel);
    ctrl.pop     = issValid && issReady;
    ctrl.take    = dmdTake;
    ctrl.free    = cmplValid && cmplSlotBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCnt <= '0;
    end else begin
      case ({ctrl.pop, ctrl.free})
        2'b10:   outCnt <= outCnt + OCNT_W'(1);
        2'b01:   outCnt <= outCnt - OCNT_W'(1);
        default: outCnt <= outCnt;
      endcase
    end
  end

endmodule

// File: rtl/pfq_datapath.sv
module pfq_datapath
  import pfq_pkg::*;
#(
  parameter int LINE_W  = 26,
  parameter int DEPTH   = 16,
  parameter int MAX_OUT = 6,
  localparam int QCNT_W = $clog2(DEPTH + 1),
  localparam int QIDX_W = $clog2(DEPTH),
  localparam int TAG_W  = $clog2(MAX_OUT)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlS                            ctrl,
  input  logic [NUM_SRC-1:0][LINE_W-1:0]  pushAddr,
  input  logic [LINE_W-1:0]               dmdAddr,
  input  logic [TAG_W-1:0]                cmplTag,
  output logic [QCNT_W-1:0]               qCount,
  output logic [LINE_W-1:0]               headAddr,
  output logic [1:0]                      headSrc,
  output logic [NUM_SRC-1:0]              dupVec,
  output logic                            dmdQHit,
  output logic                            dmdHeadHit,
  output logic                            dmdFHit,
  output logic [TAG_W-1:0]                dmdFTag,
  output logic [TAG_W-1:0]                freeTag,
  output logic                            cmplSlotBusy,
  output logic [MAX_OUT-1:0]              fltValid
);

  logic [LINE_W-1:0] qAddr [DEPTH];
  srcE               qSrc  [DEPTH];
  logic [LINE_W-1:0] fltAddr [MAX_OUT];

  logic [DEPTH-1:0]   qLive;
  logic [DEPTH-1:0]   qDmdHit;
  logic [MAX_OUT-1:0] fDmdHit;
  logic [NUM_SRC-1:0][DEPTH-1:0]   qPushHit;
  logic [NUM_SRC-1:0][MAX_OUT-1:0] fPushHit;

  // address compare arrays
  for (genvar i = 0; i < DEPTH; i++) begin : g_qcmp
    assign qLive[i]   = (QCNT_W'(i) < qCount);
    assign qDmdHit[i] = qLive[i] && (qAddr[i] == dmdAddr);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign qPushHit[s][i] = qLive[i] && (qAddr[i] == pushAddr[s]);
    end
  end

  for (genvar j = 0; j < MAX_OUT; j++) begin : g_fcmp
    assign fDmdHit[j] = fltValid[j] && (fltAddr[j] == dmdAddr);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign fPushHit[s][j] = fltValid[j] && (fltAddr[j] == pushAddr[s]);
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_dup
    assign dupVec[s] = (|qPushHit[s]) || (|fPushHit[s]);
  end

  assign dmdQHit    = |qDmdHit;
  assign dmdHeadHit = qDmdHit[0];
  assign dmdFHit    = |fDmdHit;
  assign headAddr   = qAddr[0];
  assign headSrc    = qSrc[0];

  logic [QIDX_W-1:0] takeIdx;

  always_comb begin
    takeIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (qDmdHit[i]) takeIdx = QIDX_W'(i);
    end
    dmdFTag      = '0;
    freeTag      = '0;
    cmplSlotBusy = 1'b0;
    for (int j = MAX_OUT - 1; j >= 0; j--) begin
      if (fDmdHit[j])   dmdFTag = TAG_W'(j);
      if (!fltValid[j]) freeTag = TAG_W'(j);
      if (cmplTag == TAG_W'(j)) cmplSlotBusy = fltValid[j];
    end
  end

  // next queue image: drop popped and withdrawn entries, close gaps, append
  logic [LINE_W-1:0] nAddr [DEPTH];
  srcE               nSrc  [DEPTH];
  logic [QCNT_W-1:0] wrPos;
  logic [LINE_W-1:0] selAddr;
  logic              keepIt;

  always_comb begin
    case (ctrl.pushSrc)
      SRC_TW:  selAddr = pushAddr[2];
      SRC_IF:  selAddr = pushAddr[1];
      default: selAddr = pushAddr[0];
    endcase
    for (int i = 0; i < DEPTH; i++) begin
      nAddr[i] = qAddr[i];
      nSrc[i]  = qSrc[i];
    end
    wrPos = '0;
    for (int i = 0; i < DEPTH; i++) begin
      keepIt = qLive[i] && !(ctrl.pop && (i == 0)) &&
               !(ctrl.take && (takeIdx == QIDX_W'(i)));
      if (keepIt) begin
        nAddr[wrPos[QIDX_W-1:0]] = qAddr[i];
        nSrc[wrPos[QIDX_W-1:0]]  = qSrc[i];
        wrPos = wrPos + QCNT_W'(1);
      end
    end
    if (ctrl.push && (wrPos < QCNT_W'(DEPTH))) begin
      nAddr[wrPos[QIDX_W-1:0]] = selAddr;
      nSrc[wrPos[QIDX_W-1:0]]  = ctrl.pushSrc;
      wrPos = wrPos + QCNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) qCount <= '0;
    else       qCount <= wrPos;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      qAddr[i] <= nAddr[i];
      qSrc[i]  <= nSrc[i];
    end
  end

  // in-flight slot table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fltValid <= '0;
    end else begin
      for (int j = 0; j < MAX_OUT; j++) begin
        if (ctrl.free && (cmplTag == TAG_W'(j))) fltValid[j] <= 1'b0;
        if (ctrl.pop && (freeTag == TAG_W'(j)))  fltValid[j] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < MAX_OUT; j++) begin
      if (ctrl.pop && (freeTag == TAG_W'(j))) fltAddr[j] <= qAddr[0];
    end
  end

endmodule

// File: rtl/pf_req_queue.sv
module pf_req_queue
  import pfq_pkg::*;
#(
  parameter int LINE_W  = 26,
  parameter int DEPTH   = 16,
  parameter int MAX_OUT = 6,
  localparam int QCNT_W = $clog2(DEPTH + 1),
  localparam int OCNT_W = $clog2(MAX_OUT + 1),
  localparam int TAG_W  = $clog2(MAX_OUT)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_SRC-1:0]             pushValid,
  input  logic [NUM_SRC-1:0][LINE_W-1:0] pushAddr,
  output logic [NUM_SRC-1:0]             pushReady,
  output logic                           issValid,
  input  logic                           issReady,
  output logic [LINE_W-1:0]              issAddr,
  output logic [1:0]                     issSrc,
  output logic [TAG_W-1:0]               issTag,
  output logic                           issAlloc,
  input  logic                           cmplValid,
  input  logic [TAG_W-1:0]               cmplTag,
  input  logic                           dmdValid,
  input  logic [LINE_W-1:0]              dmdAddr,
  output logic                           dmdFwd,
  output logic [TAG_W-1:0]               dmdFwdTag,
  output logic                           dmdTake
);

  ctrlS               ctrl;
  logic [QCNT_W-1:0]  qCount;
  logic [OCNT_W-1:0]  outCnt;
  logic [MAX_OUT-1:0] fltValid;
  logic [NUM_SRC-1:0] dupVec;
  logic               dmdQHit, dmdHeadHit, dmdFHit, cmplSlotBusy;

  pfq_ctrl #(.DEPTH(DEPTH), .MAX_OUT(MAX_OUT)) u_ctl (
    .clk(clk), .rstN(rstN),
    .pushValid(pushValid), .dupVec(dupVec), .qCount(qCount),
    .dmdValid(dmdValid), .dmdQHit(dmdQHit), .dmdHeadHit(dmdHeadHit),
    .dmdFHit(dmdFHit), .issReady(issReady), .cmplValid(cmplValid),
    .cmplSlotBusy(cmplSlotBusy), .pushReady(pushReady), .issValid(issValid),
    .dmdFwd(dmdFwd), .dmdTake(dmdTake), .outCnt(outCnt), .ctrl(ctrl)
  );

  pfq_datapath #(.LINE_W(LINE_W), .DEPTH(DEPTH), .MAX_OUT(MAX_OUT)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .pushAddr(pushAddr), .dmdAddr(dmdAddr), .cmplTag(cmplTag),
    .qCount(qCount), .headAddr(issAddr), .headSrc(issSrc),
    .dupVec(dupVec), .dmdQHit(dmdQHit), .dmdHeadHit(dmdHeadHit),
    .dmdFHit(dmdFHit), .dmdFTag(dmdFwdTag), .freeTag(issTag),
    .cmplSlotBusy(cmplSlotBusy), .fltValid(fltValid)
  );

  // every prefetch fills into L2
  assign issAlloc = issValid;

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int DEPTH   = 16,
  parameter int MAX_OUT = 6,
  localparam int QCNT_W = $clog2(DEPTH + 1),
  localparam int OCNT_W = $clog2(MAX_OUT + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic [2:0]         pushValid,
  input logic [2:0]         pushReady,
  input logic               issValid,
  input logic               issReady,
  input logic               cmplValid,
  input logic               dmdFwd,
  input logic               dmdTake,
  input logic [QCNT_W-1:0]  qCount,
  input logic [OCNT_W-1:0]  outCnt,
  input logic [MAX_OUT-1:0] fltValid
);

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= QCNT_W'(DEPTH));

  a_r4_full_refuse: assert property (@(posedge clk) disable iff (!rstN)
    (qCount == QCNT_W'(DEPTH)) |-> (pushReady == 3'b000));

  a_r2_tw_first: assert property (@(posedge clk) disable iff (!rstN)
    pushValid[2] |-> (pushReady[1:0] == 2'b00));

  a_r2_if_over_ls: assert property (@(posedge clk) disable iff (!rstN)
    pushValid[1] |-> !pushReady[0]);

  a_r6_cap_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (outCnt == OCNT_W'(MAX_OUT)) |-> !issValid);

  a_r6_never_over: assert property (@(posedge clk) disable iff (!rstN)
    outCnt <= OCNT_W'(MAX_OUT));

  a_r7_slots_agree: assert property (@(posedge clk) disable iff (!rstN)
    outCnt == OCNT_W'($countones(fltValid)));

  a_r7_issue_grows: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && issReady && !cmplValid) |=> (outCnt == $past(outCnt) + OCNT_W'(1)));

  a_r8_one_path: assert property (@(posedge clk) disable iff (!rstN)
    !(dmdFwd && dmdTake));

endmodule

bind pf_req_queue pfq_checker #(.DEPTH(DEPTH), .MAX_OUT(MAX_OUT)) u_chk (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushReady(pushReady),
  .issValid(issValid), .issReady(issReady), .cmplValid(cmplValid),
  .dmdFwd(dmdFwd), .dmdTake(dmdTake), .qCount(qCount), .outCnt(outCnt),
  .fltValid(fltValid)
);

// File: tb/sim_pf_req_queue.sv
module sim_pf_req_queue;

  localparam int LINE_W  = 26;
  localparam int DEPTH   = 16;
  localparam int MAX_OUT = 6;
  localparam int TAG_W   = $clog2(MAX_OUT);

  // {pushValid[2:0], expected pushReady[2:0], winning source[1:0]}
  localparam logic [7:0] VEC [8] = '{
    8'b000_111_00, 8'b001_111_00, 8'b010_110_01, 8'b011_110_01,
    8'b100_100_10, 8'b101_100_10, 8'b110_100_10, 8'b111_100_10
  };
  // issue order after line 13 is withdrawn
  localparam int DRAIN_A [6] = '{4, 9, 18, 22, 26, 30};
  localparam int DRAIN_S [6] = '{0, 1, 2, 2, 2, 2};

  logic                  clk = 1'b0;
  logic                  rstN;
  logic [2:0]            pushValid;
  logic [2:0][LINE_W-1:0] pushAddr;
  logic [2:0]            pushReady;
  logic                  issValid, issReady, issAlloc;
  logic [LINE_W-1:0]     issAddr;
  logic [1:0]            issSrc;
  logic [TAG_W-1:0]      issTag;
  logic                  cmplValid;
  logic [TAG_W-1:0]      cmplTag;
  logic                  dmdValid;
  logic [LINE_W-1:0]     dmdAddr;
  logic                  dmdFwd, dmdTake;
  logic [TAG_W-1:0]      dmdFwdTag;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  pf_req_queue #(.LINE_W(LINE_W), .DEPTH(DEPTH), .MAX_OUT(MAX_OUT)) u0 (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushAddr(pushAddr),
    .pushReady(pushReady), .issValid(issValid), .issReady(issReady),
    .issAddr(issAddr), .issSrc(issSrc), .issTag(issTag), .issAlloc(issAlloc),
    .cmplValid(cmplValid), .cmplTag(cmplTag), .dmdValid(dmdValid),
    .dmdAddr(dmdAddr), .dmdFwd(dmdFwd), .dmdFwdTag(dmdFwdTag), .dmdTake(dmdTake)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  initial begin
    rstN = 1'b0; pushValid = '0; pushAddr = '0; issReady = 1'b0;
    cmplValid = 1'b0; cmplTag = '0; dmdValid = 1'b0; dmdAddr = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(issValid == 1'b0, "R1 issValid in reset", issValid, 0);
    chk(issAlloc == 1'b0, "R1 issAlloc in reset", issAlloc, 0);
    chk(pushReady == 3'b111, "R1 pushReady in reset", pushReady, 7);
    chk(dmdFwd == 1'b0 && dmdTake == 1'b0, "R1 demand outputs in reset", {dmdFwd, dmdTake}, 0);
    @(negedge clk); rstN = 1'b1;
    #1 chk(pushReady == 3'b111, "R1 pushReady after reset", pushReady, 7);

    // R2 table walk over ready patterns, one winner per row
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      pushValid = VEC[r][7:5];
      for (int s = 0; s < 3; s++) pushAddr[s] = LINE_W'(r * 4 + s);
      #1 chk(pushReady == VEC[r][4:2], "R2 ready pattern", pushReady, VEC[r][4:2]);
    end

    // R3 duplicate of a queued line, then a fresh line
    @(negedge clk); pushValid = 3'b001; pushAddr[0] = LINE_W'(9);
    #1 chk(pushReady[0] == 1'b1, "R3 duplicate still handshakes", pushReady[0], 1);
    @(negedge clk); pushAddr[0] = LINE_W'(40);

    // R9 demand withdraws queued line 13
    @(negedge clk); pushValid = '0; dmdValid = 1'b1; dmdAddr = LINE_W'(13);
    #1 chk(dmdTake == 1'b1, "R9 dmdTake on queued line", dmdTake, 1);
    chk(dmdFwd == 1'b0, "R9 no forward for queued line", dmdFwd, 0);
    @(negedge clk);
    #1 chk(dmdTake == 1'b0 && dmdFwd == 1'b0, "R9 withdrawn line gone", {dmdFwd, dmdTake}, 0);
    @(negedge clk); dmdValid = 1'b0; issReady = 1'b1;

    // R5 in-order drain up to the cap, R7 tags 0..5, R10 alloc
    for (int k = 0; k < 6; k++) begin
      #1;
      chk(issValid == 1'b1, "R5 issValid during drain", issValid, 1);
      chk(issAddr == LINE_W'(DRAIN_A[k]), "R5 issue order", issAddr, DRAIN_A[k]);
      chk(issSrc == 2'(DRAIN_S[k]), "R2 winner source code", issSrc, DRAIN_S[k]);
      chk(issTag == TAG_W'(k), "R7 lowest free tag", issTag, k);
      chk(issAlloc == 1'b1, "R10 allocate marking", issAlloc, 1);
      @(negedge clk);
    end

    // cap reached with line 40 waiting
    pushValid = 3'b001; pushAddr[0] = LINE_W'(4);
    dmdValid = 1'b1; dmdAddr = LINE_W'(22);
    #1 chk(issValid == 1'b0, "R6 blocked at cap", issValid, 0);
    chk(pushReady[0] == 1'b1, "R3 in-flight duplicate handshakes", pushReady[0], 1);
    chk(dmdFwd == 1'b1, "R8 forward on in-flight line", dmdFwd, 1);
    chk(dmdFwdTag == TAG_W'(3), "R8 forward tag", dmdFwdTag, 3);
    chk(dmdTake == 1'b0, "R8 no take for in-flight line", dmdTake, 0);

    @(negedge clk); pushValid = '0; dmdValid = 1'b0; cmplValid = 1'b1; cmplTag = TAG_W'(2);
    #1 chk(issValid == 1'b0, "R6 completion cycle still blocked", issValid, 0);
    @(negedge clk); cmplValid = 1'b0;
    #1 chk(issValid == 1'b1, "R6 issue resumes", issValid, 1);
    chk(issAddr == LINE_W'(40), "R5 waiting line issues", issAddr, 40);
    chk(issTag == TAG_W'(2), "R7 freed slot reused", issTag, 2);

    @(negedge clk); cmplValid = 1'b1; cmplTag = '0;
    #1 chk(issValid == 1'b0, "R6 cap again", issValid, 0);
    @(negedge clk); cmplValid = 1'b0; dmdValid = 1'b1; dmdAddr = LINE_W'(4);
    #1 chk(issValid == 1'b0, "R3 dropped duplicate never issues", issValid, 0);
    chk(dmdTake == 1'b0 && dmdFwd == 1'b0, "R3 dropped duplicate not queued", {dmdFwd, dmdTake}, 0);

    // R7 spurious completion of free slot 0
    @(negedge clk); dmdValid = 1'b0; cmplValid = 1'b1; cmplTag = '0;
    @(negedge clk); cmplValid = 1'b0; pushValid = 3'b001; pushAddr[0] = LINE_W'(50);
    @(negedge clk); pushAddr[0] = LINE_W'(51);
    #1 chk(issValid == 1'b1 && issAddr == LINE_W'(50), "R5 push to issue latency", issAddr, 50);
    chk(issTag == TAG_W'(0), "R7 tag after completion", issTag, 0);
    @(negedge clk); pushValid = '0; issReady = 1'b0;
    #1 chk(issValid == 1'b0, "R7 spurious completion ignored", issValid, 0);

    // R4 fill to DEPTH (line 51 plus fifteen more)
    for (int k = 0; k < DEPTH - 1; k++) begin
      @(negedge clk); pushValid = 3'b001; pushAddr[0] = LINE_W'(100 + k);
      #1 chk(pushReady[0] == 1'b1, "R4 accepts below depth", pushReady[0], 1);
    end
    @(negedge clk); pushAddr[0] = LINE_W'(200);
    #1 chk(pushReady == 3'b000, "R4 refuse when full", pushReady, 0);
    @(negedge clk); pushValid = '0; dmdValid = 1'b1; dmdAddr = LINE_W'(51);
    #1 chk(dmdTake == 1'b1, "R9 take head of full queue", dmdTake, 1);
    @(negedge clk); dmdValid = 1'b0; cmplValid = 1'b1; cmplTag = TAG_W'(1);
    #1 chk(pushReady == 3'b111, "R4 ready after removal", pushReady, 7);
    @(negedge clk); cmplValid = 1'b0; issReady = 1'b1;
    #1 chk(issValid == 1'b1 && issAddr == LINE_W'(100), "R9 order kept after withdrawal", issAddr, 100);
    chk(issTag == TAG_W'(1), "R7 lowest free tag after completion", issTag, 1);
    @(negedge clk); issReady = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule